// File: doc/BRIEF.md
# Cascaded Periodic Tick Timer Array

This block is a bank of eight periodic timers. Each channel is a 16-bit down-counter that moves one step only when a prescaler fires. There are two prescalers, each an 8-bit down-counter running from the bus clock, and a per-channel select bit picks which one drives the channel. A prescaler reload value M gives a tick every M+1 bus cycles. A channel reload value N gives a timeout every N+1 ticks. A channel therefore expires every (M+1)*(N+1) bus cycles: from 1 up to 2^24 cycles.

On each timeout the channel does three things. It emits a one-cycle trigger pulse for neighbouring peripherals. It sets a sticky flag. If its interrupt enable is set, that flag drives its interrupt line. Software configures the block through a simple register port with single-cycle writes and combinational reads. A force command reloads a chosen set of channels, and can reload the prescalers in the same cycle. This lets several channels start in phase and keep their timeouts aligned.

Each channel is controlled by a two-state machine:
- `CH_IDLE`: the counter is held at its reload value.
- `CH_RUN`: the counter decrements on ticks.

The *start* transition (`CH_IDLE` to `CH_RUN`) is taken when both the module enable and the channel enable are set. The *stop* transition (`CH_RUN` to `CH_IDLE`) is taken as soon as either enable drops.

Top module: `tick_array_timer`

## Requirements
- R1: After reset every register reads 0, every live count reads 0, and `irq_o` and `trig_o` are all 0.
- R2: With a prescaler reload value M and a channel reload value of 0, the channel triggers every M+1 bus cycles.
- R3: With prescaler reload M and channel reload N, consecutive trigger pulses of a running channel are exactly (M+1)*(N+1) cycles apart.
- R4: A channel whose enable bit is clear holds its live count at its reload value and emits no trigger.
- R5: Bit i of register 0x02 selects the prescaler for channel i: 0 selects prescaler 0 and 1 selects prescaler 1.
- R6: Register 0x04 holds one flag per channel. A timeout sets the flag. Writing 1 to a bit clears it. A timeout in the same cycle as the clear wins, so the flag stays set.
- R7: `irq_o[i]` equals flag i AND bit i of register 0x03. The trigger pulse does not depend on the interrupt enable.
- R8: A write to register 0x05 reloads each channel named in bits 7:0. If bit 8 is also set, both prescalers reload in the same cycle. The first trigger then appears exactly (M+1)*(N+1) cycles after the write edge, so channels forced together trigger in the same cycles.
- R9: While bit 0 of register 0x00 (module enable) is clear, every counter holds its reload value, and no trigger or flag is produced.
- R10: These registers read back what was written: reload values at 0x10+i, prescaler reload values at 0x08+k, and the select bits at 0x02. Live counts are read at 0x20+i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_o | output | 8 | Per-channel interrupt, flag AND enable |
| trig_o | output | 8 | Per-channel one-cycle timeout pulse |

## Verification
The main function is tried with a table of prescaler and channel reload pairs, and the bench measures both the delay from a force write to the first trigger and the spacing between triggers:
- The pairs with a zero channel reload isolate the prescaler divider.
- The pairs with a zero prescaler reload isolate the channel divider.
- The mixed pairs expose any off-by-one in the product.
- The pair that gives a period of one cycle separates a continuously high trigger from a missing one.

Two channels with equal loads on different prescalers show that the select bit matters. Two channels started at different times, then forced together, show that alignment works. A channel that times out every cycle is used to show that a timeout wins over a simultaneous flag clear.

// File: rtl/tat_pkg.sv
package tat_pkg;

    localparam int ADDR_W       = 8;
    localparam int FORCE_MB_BIT = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_CHEN  = 8'h01;
    localparam logic [ADDR_W-1:0] A_MUX   = 8'h02;
    localparam logic [ADDR_W-1:0] A_IRQEN = 8'h03;
    localparam logic [ADDR_W-1:0] A_FLAG  = 8'h04;
    localparam logic [ADDR_W-1:0] A_FORCE = 8'h05;
    localparam logic [ADDR_W-1:0] A_MBLD  = 8'h08;
    localparam logic [ADDR_W-1:0] A_CHLD  = 8'h10;
    localparam logic [ADDR_W-1:0] A_CHCNT = 8'h20;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/tat_regs.sv
module tat_regs
    import tat_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int NUM_MB = 2,
    parameter int CH_W   = 16,
    parameter int MB_W   = 8,
    parameter int DW     = 16,
    parameter int SEL_W  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [DW-1:0]            rdata_o,
    input  logic [NUM_CH-1:0]        timeout_i,
    input  logic [NUM_CH*CH_W-1:0]   ch_cnt_i,
    output logic                     mod_en_o,
    output logic [NUM_CH-1:0]        ch_en_o,
    output logic [NUM_CH-1:0]        irq_en_o,
    output logic [NUM_CH-1:0]        flags_o,
    output logic [NUM_CH*SEL_W-1:0]  mux_o,
    output logic [NUM_MB*MB_W-1:0]   mb_ld_o,
    output logic [NUM_CH*CH_W-1:0]   ch_ld_o,
    output logic [NUM_CH-1:0]        force_ch_o,
    output logic                     force_mb_o
);

    logic                     mod_en_q;
    logic [NUM_CH-1:0]        ch_en_q;
    logic [NUM_CH-1:0]        irq_en_q;
    logic [NUM_CH-1:0]        flags_q;
    logic [NUM_CH*SEL_W-1:0]  mux_q;
    logic [MB_W-1:0]          mb_ld_q [NUM_MB];
    logic [CH_W-1:0]          ch_ld_q [NUM_CH];
    logic [NUM_CH-1:0]        clr_mask;

    assign clr_mask = (we_i && addr_i == A_FLAG) ? wdata_i[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_en_q <= 1'b0;
            ch_en_q  <= '0;
            irq_en_q <= '0;
            flags_q  <= '0;
            mux_q    <= '0;
            for (int k = 0; k < NUM_MB; k++) mb_ld_q[k] <= '0;
            for (int i = 0; i < NUM_CH; i++) ch_ld_q[i] <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | timeout_i;
            if (we_i) begin
                if (addr_i == A_CTRL)  mod_en_q <= wdata_i[0];
                if (addr_i == A_CHEN)  ch_en_q  <= wdata_i[NUM_CH-1:0];
                if (addr_i == A_IRQEN) irq_en_q <= wdata_i[NUM_CH-1:0];
                if (addr_i == A_MUX)   mux_q    <= wdata_i[NUM_CH*SEL_W-1:0];
                for (int k = 0; k < NUM_MB; k++)
                    if (addr_i == A_MBLD + 8'(k)) mb_ld_q[k] <= wdata_i[MB_W-1:0];
                for (int i = 0; i < NUM_CH; i++)
                    if (addr_i == A_CHLD + 8'(i)) ch_ld_q[i] <= wdata_i[CH_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL:  rdata_o[0]                  = mod_en_q;
            A_CHEN:  rdata_o[NUM_CH-1:0]         = ch_en_q;
            A_MUX:   rdata_o[NUM_CH*SEL_W-1:0]   = mux_q;
            A_IRQEN: rdata_o[NUM_CH-1:0]         = irq_en_q;
            A_FLAG:  rdata_o[NUM_CH-1:0]         = flags_q;
            default: ;
        endcase
        for (int k = 0; k < NUM_MB; k++)
            if (addr_i == A_MBLD + 8'(k)) rdata_o[MB_W-1:0] = mb_ld_q[k];
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr_i == A_CHLD + 8'(i))  rdata_o[CH_W-1:0] = ch_ld_q[i];
            if (addr_i == A_CHCNT + 8'(i)) rdata_o[CH_W-1:0] = ch_cnt_i[i*CH_W +: CH_W];
        end
    end

    assign force_ch_o = (we_i && addr_i == A_FORCE) ? wdata_i[NUM_CH-1:0] : '0;
    assign force_mb_o = we_i && (addr_i == A_FORCE) && wdata_i[FORCE_MB_BIT];

    assign mod_en_o = mod_en_q;
    assign ch_en_o  = ch_en_q;
    assign irq_en_o = irq_en_q;
    assign flags_o  = flags_q;
    assign mux_o    = mux_q;

    for (genvar k = 0; k < NUM_MB; k++) begin : g_mbld
        assign mb_ld_o[k*MB_W +: MB_W] = mb_ld_q[k];
    end
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chld
        assign ch_ld_o[i*CH_W +: CH_W] = ch_ld_q[i];
    end

    // R6: a write of ones clears those flags when no timeout collides
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_FLAG && timeout_i == '0)
        |=> ((flags_q & $past(wdata_i[NUM_CH-1:0])) == '0));

    // R6: a timeout always leaves its flag set, even against a clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i != '0) |=> ((flags_q & $past(timeout_i)) == $past(timeout_i)));

endmodule

// File: rtl/tat_microbase.sv
module tat_microbase #(
    parameter int MB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            reload_i,
    input  logic [MB_W-1:0] ld_i,
    output logic            tick_o
);

    logic [MB_W-1:0] cnt_q;

    assign tick_o = run_i && !reload_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (!run_i || reload_i || tick_o) cnt_q <= ld_i;
        else                                 cnt_q <= cnt_q - 1'b1;
    end

    // R2: after a tick the prescaler restarts from its reload value
    p_mb_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == $past(ld_i)));

    // R9: a stopped prescaler sits at its reload value
    p_mb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == $past(ld_i)));

endmodule

// File: rtl/tat_channel.sv
module tat_channel
    import tat_pkg::*;
#(
    parameter int CH_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            reload_i,
    input  logic            tick_i,
    input  logic [CH_W-1:0] ld_i,
    output logic [CH_W-1:0] cnt_o,
    output logic            timeout_o
);

    ch_state_e       state_q, state_d;
    logic [CH_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        timeout_o = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                cnt_d = ld_i;
                if (run_i) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (!run_i) begin
                    state_d = CH_IDLE;
                    cnt_d   = ld_i;
                end else if (reload_i) begin
                    cnt_d = ld_i;
                end else if (tick_i) begin
                    if (cnt_q == '0) begin
                        timeout_o = 1'b1;
                        cnt_d     = ld_i;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    assign cnt_o = cnt_q;

    // R4: a channel that is not allowed to run holds its reload value
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == $past(ld_i)));

    // R3: one prescaler tick moves a nonzero count down by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && run_i && tick_i && !reload_i && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8: a force reload restarts the count from the reload value
    p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (cnt_q == $past(ld_i)));

endmodule

// File: rtl/tick_array_timer.sv
module tick_array_timer
    import tat_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int NUM_MB = 2,
    parameter int CH_W   = 16,
    parameter int MB_W   = 8,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NUM_CH-1:0] irq_o,
    output logic [NUM_CH-1:0] trig_o
);

    localparam int SEL_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;

    logic                     mod_en;
    logic [NUM_CH-1:0]        ch_en, irq_en, flags, force_ch, timeout;
    logic                     force_mb;
    logic [NUM_CH*SEL_W-1:0]  mux;
    logic [NUM_MB*MB_W-1:0]   mb_ld;
    logic [NUM_CH*CH_W-1:0]   ch_ld, ch_cnt;
    logic [NUM_MB-1:0]        mb_tick;

    tat_regs #(
        .NUM_CH(NUM_CH), .NUM_MB(NUM_MB), .CH_W(CH_W),
        .MB_W(MB_W), .DW(DW), .SEL_W(SEL_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .timeout_i(timeout), .ch_cnt_i(ch_cnt),
        .mod_en_o(mod_en), .ch_en_o(ch_en), .irq_en_o(irq_en), .flags_o(flags),
        .mux_o(mux), .mb_ld_o(mb_ld), .ch_ld_o(ch_ld),
        .force_ch_o(force_ch), .force_mb_o(force_mb)
    );

    for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
        tat_microbase #(.MB_W(MB_W)) mb_i (
            .clk(clk), .rst_n(rst_n),
            .run_i(mod_en), .reload_i(force_mb),
            .ld_i(mb_ld[k*MB_W +: MB_W]), .tick_o(mb_tick[k])
        );
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [SEL_W-1:0] sel;
        logic             tick_sel;
        assign sel      = mux[i*SEL_W +: SEL_W];
        assign tick_sel = (int'(sel) < NUM_MB) ? mb_tick[sel] : 1'b0;

        tat_channel #(.CH_W(CH_W)) ch_i (
            .clk(clk), .rst_n(rst_n),
            .run_i(mod_en && ch_en[i]), .reload_i(force_ch[i]),
            .tick_i(tick_sel), .ld_i(ch_ld[i*CH_W +: CH_W]),
            .cnt_o(ch_cnt[i*CH_W +: CH_W]), .timeout_o(timeout[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_o <= '0;
        else        trig_o <= timeout;
    end

    assign irq_o = flags & irq_en;

    // R9: no trigger follows a cycle with the module disabled
    p_trig_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mod_en) == 1'b0) |-> (trig_o == '0));

    // R6: every trigger pulse is accompanied by its flag
    p_trig_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((trig_o & ~flags) == '0));

    // R7: an interrupt line never rises without its enable
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((irq_o & ~irq_en) == '0));

endmodule

// File: tb/tick_array_timer_tb.sv
module tick_array_timer_tb_top;
    import tat_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // prescaler reload, channel reload, expected period (cycles)
    localparam int unsigned VEC [NV][3] = '{
        '{0, 0, 1}, '{3, 0, 4}, '{0, 5, 6}, '{3, 4, 20},
        '{9, 2, 30}, '{1, 99, 200}, '{255, 1, 512}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  irq_o, trig_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    tick_array_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .trig_o(trig_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_trig(input int ch, input int limit, output int k);
        k = 0;
        while (!trig_o[ch] && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int v, k, m, f0, f1, mis, n2;
        idle(5);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(A_CTRL, v);      chk(v == 0, "R1 ctrl", v, 0);
        rd(A_CHLD, v);      chk(v == 0, "R1 reload", v, 0);
        rd(A_FLAG, v);      chk(v == 0, "R1 flags", v, 0);
        rd(A_CHCNT + 8'd4, v); chk(v == 0, "R1 count", v, 0);
        chk(irq_o == 0 && trig_o == 0, "R1 outputs", int'({irq_o, trig_o}), 0);

        // R10 readback
        wr(A_CHLD + 8'd3, 16'hBEEF); rd(A_CHLD + 8'd3, v); chk(v == 'hBEEF, "R10 chld", v, 'hBEEF);
        wr(A_MBLD + 8'd1, 16'h005A); rd(A_MBLD + 8'd1, v); chk(v == 'h5A, "R10 mbld", v, 'h5A);
        wr(A_MUX, 16'h00A5);         rd(A_MUX, v);         chk(v == 'hA5, "R10 mux", v, 'hA5);
        wr(A_MUX, 16'h0000);

        // R2/R3/R8 table walk on channel 0, prescaler 0
        wr(A_CTRL, 16'h0001);
        wr(A_CHEN, 16'h0001);
        for (int t = 0; t < NV; t++) begin
            wr(A_MBLD, 16'(VEC[t][0]));
            wr(A_CHLD, 16'(VEC[t][1]));
            wr(A_FORCE, 16'h0101);
            wait_trig(0, 2000, k);
            chk(k == int'(VEC[t][2]), "R8 first timeout", k, int'(VEC[t][2]));
            m = 0;
            do begin @(negedge clk); m++; end while (!trig_o[0] && m < 2000);
            if (VEC[t][1] == 0) chk(m == int'(VEC[t][2]), "R2 period", m, int'(VEC[t][2]));
            else                chk(m == int'(VEC[t][2]), "R3 period", m, int'(VEC[t][2]));
        end

        // R5 prescaler select
        wr(A_MBLD, 16'd2); wr(A_MBLD + 8'd1, 16'd4);
        wr(A_CHLD, 16'd3); wr(A_CHLD + 8'd1, 16'd3);
        wr(A_MUX, 16'h0002); wr(A_CHEN, 16'h0003);
        wr(A_FORCE, 16'h0103);
        f0 = 0; f1 = 0;
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            if (trig_o[0] && f0 == 0) f0 = c;
            if (trig_o[1] && f1 == 0) f1 = c;
        end
        chk(f0 == 12, "R5 base0", f0, 12);
        chk(f1 == 20, "R5 base1", f1, 20);

        // R8 alignment of channels started at different times
        wr(A_MUX, 16'h0000); wr(A_MBLD, 16'd1);
        wr(A_CHLD + 8'd2, 16'd5); wr(A_CHLD + 8'd3, 16'd5);
        wr(A_CHEN, 16'h0004); idle(7);
        wr(A_CHEN, 16'h000C);
        wr(A_FORCE, 16'h010C);
        mis = 0; n2 = 0;
        for (int c = 1; c <= 60; c++) begin
            @(negedge clk);
            if (trig_o[2] != trig_o[3]) mis++;
            if (trig_o[2]) n2++;
        end
        chk(mis == 0, "R8 aligned", mis, 0);
        chk(n2 == 5, "R8 pulse count", n2, 5);

        // R4 channel disable
        wr(A_CHEN, 16'h0008); idle(2);
        rd(A_CHCNT + 8'd2, v); chk(v == 5, "R4 hold", v, 5);
        n2 = 0;
        for (int c = 0; c < 30; c++) begin @(negedge clk); if (trig_o[2]) n2++; end
        chk(n2 == 0, "R4 no trigger", n2, 0);

        // R6/R7 flags, interrupts, set beats clear
        wr(A_MBLD, 16'd0); wr(A_CHLD, 16'd0); wr(A_IRQEN, 16'h0000);
        wr(A_CHEN, 16'h0001); wr(A_FORCE, 16'h0101); idle(3);
        rd(A_FLAG, v);  chk(v[0] == 1'b1, "R6 flag set", v & 1, 1);
        chk(irq_o[0] == 1'b0, "R7 irq masked", int'(irq_o[0]), 0);
        chk(trig_o[0] == 1'b1, "R7 trig w/o enable", int'(trig_o[0]), 1);
        wr(A_FLAG, 16'h0001);
        rd(A_FLAG, v);  chk(v[0] == 1'b1, "R6 set wins", v & 1, 1);
        wr(A_IRQEN, 16'h0001);
        chk(irq_o[0] == 1'b1, "R7 irq on", int'(irq_o[0]), 1);
        wr(A_CHEN, 16'h0000); idle(2);
        wr(A_FLAG, 16'h00FF);
        rd(A_FLAG, v);  chk(v == 0, "R6 w1c", v, 0);
        chk(irq_o == 0, "R7 irq clear", int'(irq_o), 0);

        // R9 module enable off
        wr(A_CTRL, 16'h0000); wr(A_CHEN, 16'h000F);
        wr(A_MBLD, 16'd3); wr(A_CHLD, 16'd7); idle(3);
        rd(A_CHCNT, v); chk(v == 7, "R9 hold", v, 7);
        n2 = 0;
        for (int c = 0; c < 100; c++) begin @(negedge clk); if (trig_o != 0) n2++; end
        chk(n2 == 0, "R9 no trigger", n2, 0);
        rd(A_FLAG, v); chk(v == 0, "R9 no flag", v, 0);
        wr(A_CTRL, 16'h0001);
        wait_trig(0, 100, k);
        chk(k < 100, "R9 resumes", k, 32);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule